// File: doc/BRIEF.md
# DDR Two-Word Burst SRAM Front End

This block is the synchronous front end of a small pipelined SRAM that moves two data words for every address, one word per clock half. It runs on a single beat clock whose rising edges stand for the alternating rising edges of the K and K# input clocks. The first rising edge after reset release is a K edge, and the edges then alternate K, K#, K, K#. Commands and addresses are taken only on K edges. Write data is taken on one K edge and the K# edge after it. Read data leaves on consecutive beats together with an echo clock that a receiver can use to capture it.

Each address names a pair of words. With narrow words (below 18 bits) the whole address selects the pair, and a burst always runs word 0 then word 1. With wide words (18 bits and above) the upper address bits select the pair and the address LSB selects the first word of the burst. The second beat then takes the other word, so the order is 0→1 or 1→0. The shared data bus is modelled as separate input and output ports plus an output-enable. A run-time select chooses whether read data follows the input-clock beat grid or the output-clock grid. The output-clock grid lags the input-clock grid by one beat.

Top module: `ddr_burst_sram`

## Requirements
- R1: Commands are sampled only on K edges (edge 0 after reset release, then every second edge). On such an edge, `loadN`=0 with `readSel`=1 starts a read and `loadN`=0 with `readSel`=0 starts a write. `loadN`=1 is a deselect and does nothing. Any command presented on a K# edge is ignored.
- R2: For a write taken on edge t, the first data word is taken from `dIn` on edge t+2 (K) and the second on edge t+3 (K#). Both are stored without any stall, and a later read returns them.
- R3: With `useOutClk`=0, a read taken on edge t drives its first word after edge t+3 and its second after edge t+4. `qEn` is high in exactly those two beats.
- R4: With `useOutClk`=1, the read words, `qEn` and the echo clocks all appear one beat later than under R3: after edges t+4 and t+5.
- R5: Narrow mode (WORD_W < 18): all address bits select the location. Writes store their first beat in word 0 and their second in word 1. Reads return word 0 then word 1.
- R6: Wide mode (WORD_W ≥ 18): addr[ADDR_W-1:1] selects the location and addr[0] selects the start word s. The first beat of a write or read is word s and the second is word s^1.
- R7: `qOut` is all zeros in every beat where `qEn` is low.
- R8: With `useOutClk`=0, `echoClk` is high in beats that follow a K edge and low in beats that follow a K# edge. With `useOutClk`=1 this pattern is one beat later. `echoClkN` is always the complement. The first word of every burst is driven while `echoClk` is low.
- R9: A read issued on the K edge right after a write command, to the same address, returns the newly written words.
- R10: While reset is asserted, `qEn`=0, `qOut`=0, `echoClk`=0 and `echoClkN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; rising edges alternate K, K# |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadN | input | 1 | Active-low command strobe, sampled on K edges |
| readSel | input | 1 | 1 = read, 0 = write, sampled with the strobe |
| addr | input | ADDR_W | Word-pair address (LSB is the start word in wide mode) |
| dIn | input | WORD_W | Write data, one word per beat |
| useOutClk | input | 1 | 1 = launch reads on the output-clock grid (one beat later) |
| qOut | output | WORD_W | Read data |
| qEn | output | 1 | Output enable, high only while read data is driven |
| echoClk | output | 1 | Echo clock aligned with read data |
| echoClkN | output | 1 | Complement of echoClk |

## Verification
Counting from the K edge t that takes a read, the first word is due after edge t+3 and the second after edge t+4. Both move to t+4 and t+5 when the output-clock grid is chosen. The echo level after edge b is set by the parity of b and the grid in use. Write data is due on `dIn` before edges t+2 and t+3. The bench lays the whole stimulus out on a beat-indexed timeline and computes an expected output for every beat index from these offsets. It drives inputs and compares all outputs at the falling edge after each beat's rising edge, so every comparison falls exactly in the beat the offsets name. Two instances, one narrow and one wide, share the stimulus, and the run repeats under both output grids.

// File: rtl/ddr_sram_pkg.sv
`timescale 1ns/1ps
package ddr_sram_pkg;

  // Strobes handed from control to datapath for the current beat.
  typedef struct packed {
    logic kEdge;     // the coming edge is a K edge
    logic capFirst;  // capture first write word on the coming edge
    logic commit;    // write the word pair on the coming edge
    logic launch;    // drive one read word on the coming edge
  } beatStrobes_t;

  function automatic bit wideWords(int wordW);
    return wordW >= 18;
  endfunction

endpackage

// File: rtl/ddr_sram_ctrl.sv
`timescale 1ns/1ps
module ddr_sram_ctrl
  import ddr_sram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter bit WIDE   = 1'b1,
  localparam int LOC_W = WIDE ? ADDR_W - 1 : ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadN,
  input  logic              readSel,
  input  logic [ADDR_W-1:0] addr,
  output beatStrobes_t      strb,
  output logic [LOC_W-1:0]  wrLoc,
  output logic              wrWord,
  output logic [LOC_W-1:0]  rdLoc,
  output logic              rdWord
);

  localparam int WR_STAGES = 3;
  localparam int RD_STAGES = 4;

  logic                 phase;
  logic                 kEdge;
  logic                 newWr;
  logic                 newRd;
  logic [WR_STAGES-1:0] wrSh;
  logic [RD_STAGES-1:0] rdSh;
  logic [ADDR_W-1:0]    wrA [WR_STAGES];
  logic [ADDR_W-1:0]    rdA [RD_STAGES];

  function automatic logic [LOC_W-1:0] locOf(logic [ADDR_W-1:0] a);
    return LOC_W'(a >> (WIDE ? 1 : 0));
  endfunction

  function automatic logic startOf(logic [ADDR_W-1:0] a);
    return WIDE ? a[0] : 1'b0;
  endfunction

  assign kEdge = ~phase;
  assign newWr = kEdge & ~loadN & ~readSel;
  assign newRd = kEdge & ~loadN &  readSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      wrSh  <= '0;
      rdSh  <= '0;
      for (int i = 0; i < WR_STAGES; i++) wrA[i] <= '0;
      for (int i = 0; i < RD_STAGES; i++) rdA[i] <= '0;
    end else begin
      phase  <= ~phase;
      wrSh   <= {wrSh[WR_STAGES-2:0], newWr};
      rdSh   <= {rdSh[RD_STAGES-2:0], newRd};
      wrA[0] <= addr;
      rdA[0] <= addr;
      for (int i = 1; i < WR_STAGES; i++) wrA[i] <= wrA[i-1];
      for (int i = 1; i < RD_STAGES; i++) rdA[i] <= rdA[i-1];
    end
  end

  always_comb begin
    strb.kEdge    = kEdge;
    strb.capFirst = wrSh[1];
    strb.commit   = wrSh[2];
    strb.launch   = rdSh[2] | rdSh[3];
    wrLoc         = locOf(wrA[2]);
    wrWord        = startOf(wrA[2]);
    if (rdSh[2]) begin
      rdLoc  = locOf(rdA[2]);
      rdWord = startOf(rdA[2]);
    end else begin
      rdLoc  = locOf(rdA[3]);
      rdWord = ~startOf(rdA[3]);
    end
  end

  // R1: the edge after a K# edge never carries a freshly accepted command
  p_cmd_on_k_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> (!wrSh[0] && !rdSh[0]));

  // R3: two read bursts never compete for the same launch beat
  p_no_launch_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rdSh[2], rdSh[3]}));

  // R9: array write and read launch never fall on the same edge
  p_no_rw_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.commit && strb.launch));

endmodule

// File: rtl/ddr_sram_datapath.sv
`timescale 1ns/1ps
module ddr_sram_datapath
  import ddr_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int LOC_W  = 3,
  localparam int LOCS  = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  beatStrobes_t      strb,
  input  logic [LOC_W-1:0]  wrLoc,
  input  logic              wrWord,
  input  logic [LOC_W-1:0]  rdLoc,
  input  logic              rdWord,
  input  logic [WORD_W-1:0] dIn,
  input  logic              useOutClk,
  output logic [WORD_W-1:0] qOut,
  output logic              qEn,
  output logic              echoClk
);

  logic [WORD_W-1:0] mem [LOCS][2];
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] qK, qC;
  logic              qEnK, qEnC;
  logic              cqK, cqC;

  // Array and first-word holding register: no reset needed.
  always_ff @(posedge clk) begin
    if (strb.capFirst) hold <= dIn;
    if (strb.commit) begin
      mem[wrLoc][wrWord]  <= hold;
      mem[wrLoc][~wrWord] <= dIn;
    end
  end

  // Output stage on the input-clock grid, then one beat later for the output-clock grid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qK   <= '0;
      qEnK <= 1'b0;
      cqK  <= 1'b0;
      qC   <= '0;
      qEnC <= 1'b0;
      cqC  <= 1'b0;
    end else begin
      qEnK <= strb.launch;
      qK   <= strb.launch ? mem[rdLoc][rdWord] : '0;
      cqK  <= strb.kEdge;
      qC   <= qK;
      qEnC <= qEnK;
      cqC  <= cqK;
    end
  end

  assign qOut    = useOutClk ? qC   : qK;
  assign qEn     = useOutClk ? qEnC : qEnK;
  assign echoClk = useOutClk ? cqC  : cqK;

  // R2: a pair is committed only right after its first word was captured
  p_commit_after_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |-> $past(strb.capFirst));

  // R3: every burst on the K grid lasts two beats
  p_burst_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qEnK) |=> qEnK);

  // R4: the output-clock grid follows the K grid one beat later
  p_c_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qEnK |=> qEnC);

  // R7: idle output is zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !qEnK |-> (qK == '0));

  // R8: first word of a burst rides the low half of the echo clock
  p_first_word_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qEnK) |-> !cqK);

endmodule

// File: rtl/ddr_burst_sram.sv
`timescale 1ns/1ps
module ddr_burst_sram
  import ddr_sram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadN,
  input  logic              readSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dIn,
  input  logic              useOutClk,
  output logic [WORD_W-1:0] qOut,
  output logic              qEn,
  output logic              echoClk,
  output logic              echoClkN
);

  localparam bit WIDE  = wideWords(WORD_W);
  localparam int LOC_W = WIDE ? ADDR_W - 1 : ADDR_W;

  beatStrobes_t     strb;
  logic [LOC_W-1:0] wrLoc, rdLoc;
  logic             wrWord, rdWord;

  ddr_sram_ctrl #(.ADDR_W(ADDR_W), .WIDE(WIDE)) uCtrl (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .readSel(readSel), .addr(addr),
    .strb(strb), .wrLoc(wrLoc), .wrWord(wrWord), .rdLoc(rdLoc), .rdWord(rdWord)
  );

  ddr_sram_datapath #(.WORD_W(WORD_W), .LOC_W(LOC_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrLoc(wrLoc), .wrWord(wrWord),
    .rdLoc(rdLoc), .rdWord(rdWord), .dIn(dIn), .useOutClk(useOutClk),
    .qOut(qOut), .qEn(qEn), .echoClk(echoClk)
  );

  assign echoClkN = ~echoClk;

endmodule

// File: tb/sim_ddr_burst_sram.sv
`timescale 1ns/1ps
module sim_ddr_burst_sram;

  localparam int NB = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadN = 1'b1;
  logic        readSel = 1'b0;
  logic        useOutClk = 1'b0;
  logic [3:0]  addr = '0;
  logic [17:0] dIn = '0;

  logic [17:0] q0;
  logic        en0, e0, e0n;
  logic [7:0]  q1;
  logic        en1, e1, e1n;

  // Stimulus timeline, indexed by beat (rising edge after reset release).
  logic        stLoad [NB];
  logic        stRd   [NB];
  logic [3:0]  stAddr [NB];
  logic [17:0] stD    [NB];
  int          rdTag0 [NB];
  int          rdTag1 [NB];
  // Expected outputs, indexed by the beat after whose edge they are seen.
  logic        expEn  [NB];
  logic [17:0] expQ0  [NB];
  logic [7:0]  expQ1  [NB];
  int          tag0   [NB];
  int          tag1   [NB];
  // Memory models: wide (8 pairs) and narrow (16 pairs).
  logic [17:0] m0 [8][2];
  logic [7:0]  m1 [16][2];

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_burst_sram #(.WORD_W(18), .ADDR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .readSel(readSel), .addr(addr),
    .dIn(dIn), .useOutClk(useOutClk), .qOut(q0), .qEn(en0), .echoClk(e0), .echoClkN(e0n)
  );

  ddr_burst_sram #(.WORD_W(8), .ADDR_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .loadN(loadN), .readSel(readSel), .addr(addr),
    .dIn(dIn[7:0]), .useOutClk(useOutClk), .qOut(q1), .qEn(en1), .echoClk(e1), .echoClkN(e1n)
  );

  task automatic check(int req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] wordA(int a, int round);
    return 18'(a * 4099 + round * 777 + 'h155);
  endfunction

  task automatic putCmd(int b, bit rd, int a, int t0, int t1);
    stLoad[b] = 1'b0;
    stRd[b]   = rd;
    stAddr[b] = 4'(a);
    rdTag0[b] = t0;
    rdTag1[b] = t1;
  endtask

  task automatic putWrite(int b, int a, int round);
    logic [17:0] w;
    w = wordA(a, round);
    putCmd(b, 1'b0, a, 0, 0);
    stD[b+2] = w;               // R2: first word on edge t+2
    stD[b+3] = w ^ 18'h2AA5A;   // R2: second word on edge t+3
  endtask

  task automatic buildSchedule();
    for (int b = 0; b < NB; b++) begin
      stLoad[b] = 1'b1;
      stRd[b]   = 1'b0;
      stAddr[b] = 4'(b);
      stD[b]    = 18'h3C3C3 ^ 18'(b * 97);
      rdTag0[b] = 0;
      rdTag1[b] = 0;
    end
    // Fill every address with back-to-back writes.
    for (int a = 0; a < 16; a++) putWrite(2 * a, a, 0);
    // Read every address back: wide order checks R6, narrow order checks R5.
    for (int a = 0; a < 16; a++) putCmd(32 + 2 * a, 1'b1, a, 6, 5);
    // Write then read the same address on the next K edge: R9 (wide) and R2 (narrow).
    for (int k = 0; k < 8; k++) begin
      putWrite(64 + 4 * k, (k * 5) % 16, 1);
      putCmd(66 + 4 * k, 1'b1, (k * 5) % 16, 9, 2);
    end
    // R1: commands on K# edges are ignored; deselect on a K edge does nothing.
    putCmd(97, 1'b1, 3, 0, 0);
    putCmd(99, 1'b0, 6, 0, 0);
    stLoad[100] = 1'b1;
    stRd[100]   = 1'b1;
    putCmd(102, 1'b1, 3, 1, 1);
    putCmd(104, 1'b1, 6, 1, 1);
  endtask

  task automatic buildModel(int pass);
    int a, l, s, lat;
    for (int b = 0; b < NB; b++) begin
      expEn[b] = 1'b0;
      expQ0[b] = '0;
      expQ1[b] = '0;
      tag0[b]  = 7;   // R7: zero output while idle
      tag1[b]  = 7;
    end
    for (int b = 0; b < NB; b += 2) begin
      if (!stLoad[b]) begin
        a = int'(stAddr[b]);
        l = a >> 1;
        s = a & 1;
        if (!stRd[b]) begin
          m0[l][s]     = stD[b+2];
          m0[l][1 - s] = stD[b+3];
          m1[a][0]     = stD[b+2][7:0];
          m1[a][1]     = stD[b+3][7:0];
        end else begin
          lat = b + 3 + pass;   // R3 / R4 latency
          expEn[lat]   = 1'b1;
          expEn[lat+1] = 1'b1;
          expQ0[lat]   = m0[l][s];
          expQ0[lat+1] = m0[l][1 - s];
          expQ1[lat]   = m1[a][0];
          expQ1[lat+1] = m1[a][1];
          tag0[lat] = rdTag0[b];  tag0[lat+1] = rdTag0[b];
          tag1[lat] = rdTag1[b];  tag1[lat+1] = rdTag1[b];
        end
      end
    end
  endtask

  task automatic applyBeat(int b);
    if (b < NB) begin
      loadN   = stLoad[b];
      readSel = stRd[b];
      addr    = stAddr[b];
      dIn     = stD[b];
    end else begin
      loadN = 1'b1;
      readSel = 1'b0;
    end
  endtask

  task automatic checkBeat(int b, int pass);
    logic expE;
    int latReq;
    latReq = (pass != 0) ? 4 : 3;  // R3 on the K grid, R4 on the output-clock grid
    check(latReq, "wide qEn", 32'(en0), 32'(expEn[b]));
    check(latReq, "narrow qEn", 32'(en1), 32'(expEn[b]));
    check(tag0[b], "wide qOut", 32'(q0), 32'(expQ0[b]));
    check(tag1[b], "narrow qOut", 32'(q1), 32'(expQ1[b]));
    expE = (pass != 0) ? ((b % 2) == 1) : ((b % 2) == 0);
    // R8: echo level and complement
    check(8, "wide echoClk", 32'(e0), 32'(expE));
    check(8, "wide echoClkN", 32'(e0n), 32'(!expE));
    check(8, "narrow echoClk", 32'(e1), 32'(expE));
    check(8, "narrow echoClkN", 32'(e1n), 32'(!expE));
  endtask

  initial begin
    buildSchedule();
    for (int pass = 0; pass < 2; pass++) begin
      useOutClk = pass[0];
      rst_n = 1'b0;
      applyBeat(NB);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check(10, "wide qEn in reset", 32'(en0), 32'd0);
      check(10, "wide qOut in reset", 32'(q0), 32'd0);
      check(10, "wide echoClk in reset", 32'(e0), 32'd0);
      check(10, "wide echoClkN in reset", 32'(e0n), 32'd1);
      check(10, "narrow qEn in reset", 32'(en1), 32'd0);
      check(10, "narrow qOut in reset", 32'(q1), 32'd0);
      buildModel(pass);
      applyBeat(0);
      rst_n = 1'b1;
      for (int b = 0; b < NB; b++) begin
        @(posedge clk);
        @(negedge clk);
        checkBeat(b, pass);
        applyBeat(b + 1);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule